// File: doc/BRIEF.md
# Bad Start-of-Stream Error Handler

This block sits in a 100 Mb/s receive path, after symbol alignment and code-group decoding. Each incoming item is one received 5B code group. The decoder labels the group by kind (data, IDLE, valid start-of-stream delimiter, bad start-of-stream delimiter) and supplies the decoded nibble and a fifth bit. The block forwards each item toward an MII-style receive interface. When detection is enabled and a bad delimiter arrives, the block enters an error state. In that state every symbol leaves as the error pattern with carrier sense held, until two IDLE code groups in a row have been received.

The output format follows a mode pin. In normal mode the error flag is carried on its own pin. In transparent 5-bit mode the error flag becomes data bit 4, so an overridden symbol reads 11110 on bits 4..0. An alignment-bypass pin turns the whole override off and passes every symbol through untouched.

Both edges of the block use valid/ready. An item moves when valid and ready are both high at a rising clock edge. The input is ready whenever the single output register is empty or is being drained in the same cycle. While the output is stalled, its valid and data hold steady. Configuration pins are sampled at the edge on which each item is accepted.

Top module: `bssd_guard`

## Requirements
- R1: A synchronous reset empties the output register (out_valid = 0, in_ready = 1) and clears the error state and the IDLE counter.
- R2: in_ready = !out_valid || out_ready. While out_valid = 1 and out_ready = 0, out_valid stays 1 and the output fields keep their values.
- R3: When in_kind = 2'b11 (bad delimiter) is accepted with cfg_detect_en = 1 and cfg_bypass_align = 0, that symbol leaves with out_rxd = 4'b1110, the error flag set and out_crs = 1, and the error state is entered.
- R4: While the error state is held, every accepted symbol leaves overridden with out_crs = 1. This covers data (2'b00), valid delimiter (2'b10), bad delimiter and an IDLE (2'b01) that is not the releasing one.
- R5: In the error state, the second of two consecutive IDLE groups releases the error. That symbol leaves unmodified with out_crs = 0, and later symbols pass through.
- R6: In the error state, any non-IDLE group received before the second IDLE resets the IDLE count to zero.
- R7: With cfg_raw5 = 0, out_er is the error flag (the in_hi value on pass-through, 1 on override) and out_d4 = 0. With cfg_raw5 = 1, out_er = 0 and out_d4 is bit 4 (in_hi on pass-through, 1 on override), so an override reads {out_d4,out_rxd} = 5'b11110.
- R8: With cfg_detect_en = 0, a bad delimiter outside the error state passes through unmodified and no error state is entered.
- R9: With cfg_bypass_align = 1, every symbol passes through unmodified whatever cfg_detect_en says. A held error state is dropped and no error state is entered.
- R10: Outside the error state, symbols pass through unmodified, a valid delimiter included, with out_crs = 1 for every kind except IDLE, which gives out_crs = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_detect_en | input | 1 | Enables bad-delimiter detection |
| cfg_raw5 | input | 1 | Transparent 5-bit output format |
| cfg_bypass_align | input | 1 | Suppresses all override |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item accepted when high with in_valid |
| in_kind | input | 2 | 00 data, 01 IDLE, 10 valid delimiter, 11 bad delimiter |
| in_nibble | input | 4 | Decoded nibble |
| in_hi | input | 1 | Upstream error flag (normal) or bit 4 (transparent) |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Downstream accepts output item |
| out_rxd | output | 4 | Receive data bits 3..0 |
| out_er | output | 1 | Receive error flag (normal mode) |
| out_d4 | output | 1 | Receive data bit 4 (transparent mode) |
| out_crs | output | 1 | Carrier sense |

## Verification
The hardest situation to reach is a release that nearly happens and then does not. A single IDLE inside the error state is followed by a non-IDLE group, and only a later pair of IDLEs may end the error. The stimulus interleaves bad delimiters, lone IDLEs and data, and throttles out_ready so that stalls fall on the releasing symbol. Bypass and disable are then switched while an error is held, to show that bypass drops the state at once.

// File: rtl/bssd_pkg.sv
package bssd_pkg;
  typedef enum logic [1:0] {
    GRP_DATA = 2'b00,
    GRP_IDLE = 2'b01,
    GRP_SSD  = 2'b10,
    GRP_BAD  = 2'b11
  } grp_kind_t;

  localparam logic [3:0] ERR_NIBBLE = 4'b1110;
endpackage

// File: rtl/bssd_track.sv
module bssd_track
  import bssd_pkg::*;
#(
  parameter int IDLE_NEED = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  grp_kind_t kind,
  input  logic      detect_en,
  input  logic      bypass,
  output logic      override,
  output logic      err_q
);
  localparam int CW = $clog2(IDLE_NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_NEED - 1);

  logic [CW-1:0] idle_cnt;
  logic          releasing;

  always_comb begin
    releasing = err_q && (kind == GRP_IDLE) && (idle_cnt == LAST);
    override  = !bypass && !releasing &&
                (err_q || (detect_en && kind == GRP_BAD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= 1'b0;
      idle_cnt <= '0;
    end else if (step) begin
      err_q <= override;
      if (override && err_q && kind == GRP_IDLE)
        idle_cnt <= idle_cnt + 1'b1;
      else
        idle_cnt <= '0;
    end
  end

  // R5
  release_clears_chk: assert property (@(posedge clk) disable iff (rst)
    step && err_q && kind == GRP_IDLE && idle_cnt == LAST |=> !err_q);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= LAST);

  // R9
  bypass_drop_chk: assert property (@(posedge clk) disable iff (rst)
    step && bypass |=> !err_q);
endmodule

// File: rtl/bssd_format.sv
module bssd_format
  import bssd_pkg::*;
(
  input  logic       override,
  input  grp_kind_t  kind,
  input  logic [3:0] nibble,
  input  logic       hi,
  input  logic       raw5,
  output logic [3:0] rxd,
  output logic       er,
  output logic       d4,
  output logic       crs
);
  logic flag;

  always_comb begin
    rxd  = override ? ERR_NIBBLE : nibble;
    flag = override ? 1'b1 : hi;
    er   = raw5 ? 1'b0 : flag;
    d4   = raw5 ? flag : 1'b0;
    crs  = override || (kind != GRP_IDLE);
  end
endmodule

// File: rtl/bssd_guard.sv
module bssd_guard
  import bssd_pkg::*;
#(
  parameter int IDLE_NEED = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_detect_en,
  input  logic       cfg_raw5,
  input  logic       cfg_bypass_align,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_kind,
  input  logic [3:0] in_nibble,
  input  logic       in_hi,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [3:0] out_rxd,
  output logic       out_er,
  output logic       out_d4,
  output logic       out_crs
);
  grp_kind_t  kind;
  logic       accept, override, err_q;
  logic [3:0] f_rxd;
  logic       f_er, f_d4, f_crs;

  assign kind     = grp_kind_t'(in_kind);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  bssd_track #(.IDLE_NEED(IDLE_NEED)) u_track (
    .clk(clk), .rst(rst), .step(accept), .kind(kind),
    .detect_en(cfg_detect_en), .bypass(cfg_bypass_align),
    .override(override), .err_q(err_q)
  );

  bssd_format u_format (
    .override(override), .kind(kind), .nibble(in_nibble), .hi(in_hi),
    .raw5(cfg_raw5), .rxd(f_rxd), .er(f_er), .d4(f_d4), .crs(f_crs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rxd   <= '0;
      out_er    <= 1'b0;
      out_d4    <= 1'b0;
      out_crs   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_rxd   <= f_rxd;
        out_er    <= f_er;
        out_d4    <= f_d4;
        out_crs   <= f_crs;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_rxd, out_er, out_d4, out_crs}));

  // R3
  bad_override_chk: assert property (@(posedge clk) disable iff (rst)
    accept && kind == GRP_BAD && cfg_detect_en && !cfg_bypass_align |=>
      out_rxd == ERR_NIBBLE && out_crs && err_q);

  // R8
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    accept && kind == GRP_BAD && !cfg_detect_en && !cfg_bypass_align && !err_q
      |=> out_rxd == $past(in_nibble) && !err_q);

  // R9
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    accept && cfg_bypass_align |=> out_rxd == $past(in_nibble));

  // R7
  raw5_format_chk: assert property (@(posedge clk) disable iff (rst)
    accept && cfg_raw5 |=> !out_er);
endmodule

// File: tb/bssd_guard_bench.sv
module bssd_guard_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_detect_en = 1'b1, cfg_raw5 = 1'b0, cfg_bypass_align = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_kind = 2'b01;
  logic [3:0] in_nibble = 4'h0;
  logic in_hi = 1'b0;
  logic out_valid, out_ready;
  logic [3:0] out_rxd;
  logic out_er, out_d4, out_crs;

  always #10 clk = ~clk;

  bssd_guard u_bssd_guard (
    .clk(clk), .rst(rst), .cfg_detect_en(cfg_detect_en), .cfg_raw5(cfg_raw5),
    .cfg_bypass_align(cfg_bypass_align), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_nibble(in_nibble), .in_hi(in_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_rxd(out_rxd),
    .out_er(out_er), .out_d4(out_d4), .out_crs(out_crs)
  );

  typedef struct {
    logic [6:0] v;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic m_err = 1'b0;
  int   m_idles = 0;
  logic monitor_on = 1'b0;
  int   cyc = 0;

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [3:0] nib, input logic hi,
                      input string req);
    logic ovr, rel, flag;
    exp_t e;
    in_valid  = 1'b1;
    in_kind   = k;
    in_nibble = nib;
    in_hi     = hi;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    rel = m_err && k == 2'b01 && m_idles == 1;
    ovr = !cfg_bypass_align && !rel && (m_err || (cfg_detect_en && k == 2'b11));
    if (ovr && m_err && k == 2'b01) m_idles++;
    else m_idles = 0;
    m_err = ovr;
    flag = ovr ? 1'b1 : hi;
    e.v[6:3] = ovr ? 4'b1110 : nib;
    e.v[2]   = cfg_raw5 ? 1'b0 : flag;
    e.v[1]   = cfg_raw5 ? flag : 1'b0;
    e.v[0]   = ovr || (k != 2'b01);
    e.req    = req;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [6:0] held;
  logic was_stall = 1'b0;
  always @(negedge clk) begin
    cyc++;
    out_ready = (cyc % 5 != 2) && (cyc % 7 != 3);
    #1;
    if (monitor_on) begin
      if (was_stall)
        check("R2", {out_valid, out_rxd, out_er, out_d4}, {1'b1, held[6:1]});
      was_stall = out_valid && !out_ready;
      held = {out_rxd, out_er, out_d4, out_crs};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual=unexpected item expected=none");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, {out_rxd, out_er, out_d4, out_crs}, e.v);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1", {5'b0, out_valid, in_ready}, {5'b0, 1'b0, 1'b1});
    monitor_on = 1'b1;
    @(negedge clk);
    // R10 pass-through outside error
    send(2'b01, 4'h5, 1'b0, "R10");
    send(2'b10, 4'h5, 1'b0, "R10");
    send(2'b00, 4'hA, 1'b1, "R10");
    // R3 bad delimiter enters error
    send(2'b11, 4'h3, 1'b0, "R3");
    send(2'b00, 4'h7, 1'b0, "R4");
    send(2'b10, 4'h1, 1'b0, "R4");
    // R6 lone IDLE then data resets count
    send(2'b01, 4'h0, 1'b0, "R4");
    send(2'b00, 4'h9, 1'b0, "R6");
    send(2'b01, 4'h0, 1'b0, "R6");
    // R5 second consecutive IDLE releases
    send(2'b01, 4'h0, 1'b0, "R5");
    send(2'b00, 4'hC, 1'b0, "R5");
    // R7 transparent format
    cfg_raw5 = 1'b1;
    send(2'b00, 4'h6, 1'b1, "R7");
    send(2'b11, 4'h2, 1'b0, "R7");
    send(2'b01, 4'h0, 1'b0, "R7");
    send(2'b01, 4'h0, 1'b1, "R7");
    cfg_raw5 = 1'b0;
    // R8 detection disabled
    cfg_detect_en = 1'b0;
    send(2'b11, 4'h4, 1'b0, "R8");
    send(2'b00, 4'h8, 1'b0, "R8");
    cfg_detect_en = 1'b1;
    // R9 bypass drops held error
    send(2'b11, 4'hB, 1'b0, "R3");
    cfg_bypass_align = 1'b1;
    send(2'b00, 4'hD, 1'b0, "R9");
    send(2'b11, 4'hE, 1'b1, "R9");
    cfg_bypass_align = 1'b0;
    send(2'b00, 4'hF, 1'b0, "R9");
    // R1 reset clears error
    send(2'b11, 4'h1, 1'b0, "R3");
    while (exp_q.size() != 0) @(negedge clk);
    monitor_on = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_err = 1'b0; m_idles = 0;
    #2;
    check("R1", {5'b0, out_valid, in_ready}, {5'b0, 1'b0, 1'b1});
    was_stall = 1'b0;
    monitor_on = 1'b1;
    send(2'b00, 4'h2, 1'b0, "R1");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule